// File: doc/BRIEF.md
# Power-Good Strap Capture Sequencer

This block brings a clock generator out of power-up. It watches an active-low power-good input that arrives from outside the clock domain and passes it through a two-flop synchronizer. Once it sees power-good low, it waits a programmable settling interval with power-good held low. It then captures the frequency-select strap pins in a single clock cycle and waits a programmable lock interval for the PLL. After that it raises one output enable that gates every clock output.

The strap capture happens once per supply cycle. After the enable is up, the sequencer takes no further notice of power-good, and the strap readback holds its captured value. Only the active-low reset, which stands for removal of the core supply, starts the sequence again. If power-good returns high during the settling interval, the sequencer gives up that attempt and waits in idle for power-good to go low again. Both intervals are counted in reference-clock cycles and set by parameters: about 0.25 ms and 1.8 ms at 14.318 MHz by default. All pins are plain level signals with no handshake.

Top module: `pgs_seq_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_en_o` is 0 and `strap_rb_o` is all zeros.
- R2: While `pwrgood_ni` stays high, the sequencer stays idle and `out_en_o` stays 0 however long it waits.
- R3: The strap value captured and shown on `strap_rb_o` is the one present on `strap_i` just before rising edge number SETTLE_CYC+4. Edges are counted from 1, starting with the first rising edge that sees `pwrgood_ni` low.
- R4: `out_en_o` becomes 1 after exactly SETTLE_CYC+LOCK_CYC+4 rising edges, counted from the same first edge.
- R5: `out_en_o` is 0 in every state except the final running state. In particular it is still 0 after SETTLE_CYC+LOCK_CYC+3 edges.
- R6: If `pwrgood_ni` returns high before the settling interval ends, the sequencer returns to idle without capturing. The next low level starts the full timing of R3 and R4 again.
- R7: Once `out_en_o` is 1, toggling `pwrgood_ni` has no effect, and `out_en_o` stays 1 until reset.
- R8: After the capture, changes on `strap_i` do not change `strap_rb_o`.
- R9: Asserting reset in the running state drops `out_en_o` to 0 and clears `strap_rb_o`. The sequence then restarts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock that counts the delays |
| rst_ni | input | 1 | Active-low asynchronous reset; stands for core supply removal |
| pwrgood_ni | input | 1 | Asynchronous active-low power-good |
| strap_i | input | STRAP_W | Frequency-select strap pins |
| strap_rb_o | output | STRAP_W | Strap value captured during the sequence |
| out_en_o | output | 1 | Global output enable, high in the running state only |

## Verification
The embedded assertions check on every cycle the rules on state moves. Idle holds while power-good is high, a rise in power-good during settling sends the sequencer back to idle, and the running state is never left. The readback changes only in the capture state, the enable rises only from the lock wait, and the counter never passes its limit. Only the bench scenarios show the exact edge on which the straps are taken and the enable rises. They also show that a full restart follows an aborted attempt and that a reset during running clears everything.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_SAMPLE = 3'd2,
    ST_LOCK   = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= RST_VAL;
          else         chain_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= RST_VAL;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pgs_delay_cnt.sv
module pgs_delay_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == limit_i);

  // R4: the count stays within the active limit
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (cnt_q <= limit_i));
endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
  import pgs_pkg::*;
#(
  parameter int SETTLE_CYC = 3580,
  parameter int LOCK_CYC   = 25773,
  parameter int CNT_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pg_low_i,
  input  logic             cnt_done_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic [CNT_W-1:0] cnt_limit_o,
  output logic             capture_o,
  output logic             run_o
);
  localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LIM   = CNT_W'(LOCK_CYC - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    cnt_clr_o   = 1'b0;
    cnt_inc_o   = 1'b0;
    cnt_limit_o = SETTLE_LIM;
    unique case (state_q)
      ST_IDLE: begin
        cnt_clr_o = 1'b1;
        if (pg_low_i) state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (!pg_low_i) begin
          state_d   = ST_IDLE;
          cnt_clr_o = 1'b1;
        end else if (cnt_done_i) begin
          state_d   = ST_SAMPLE;
          cnt_clr_o = 1'b1;
        end else begin
          cnt_inc_o = 1'b1;
        end
      end
      ST_SAMPLE: begin
        cnt_clr_o = 1'b1;
        state_d   = ST_LOCK;
      end
      ST_LOCK: begin
        cnt_limit_o = LOCK_LIM;
        if (cnt_done_i) begin
          state_d   = ST_RUN;
          cnt_clr_o = 1'b1;
        end else begin
          cnt_inc_o = 1'b1;
        end
      end
      ST_RUN: state_d = ST_RUN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign capture_o = (state_q == ST_SAMPLE);
  assign run_o     = (state_q == ST_RUN);

  // R2: idle holds while power-good is inactive
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !pg_low_i) |=> state_q == ST_IDLE);
  // R6: power-good rising during settling aborts to idle
  a_r6_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE && !pg_low_i) |=> state_q == ST_IDLE);
  // R3: capture is reached only from the settle state
  a_r3_sample_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(capture_o) |-> $past(state_q) == ST_SETTLE);
  // R7: the running state is never left
  a_r7_run_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN |=> state_q == ST_RUN);
endmodule

// File: rtl/pgs_seq_top.sv
module pgs_seq_top #(
  parameter int STRAP_W    = 3,
  parameter int SETTLE_CYC = 3580,
  parameter int LOCK_CYC   = 25773,
  parameter int SYNC_STG   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwrgood_ni,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [STRAP_W-1:0] strap_rb_o,
  output logic               out_en_o
);
  localparam int MAX_CYC = (SETTLE_CYC > LOCK_CYC) ? SETTLE_CYC : LOCK_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             pg_sync;
  logic             cnt_clr, cnt_inc, cnt_done, capture, run;
  logic [CNT_W-1:0] cnt_limit;
  logic [STRAP_W-1:0] strap_q;

  pgs_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(pwrgood_ni), .sync_o(pg_sync)
  );

  pgs_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .limit_i(cnt_limit), .done_o(cnt_done)
  );

  pgs_fsm #(.SETTLE_CYC(SETTLE_CYC), .LOCK_CYC(LOCK_CYC), .CNT_W(CNT_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pg_low_i(!pg_sync),
    .cnt_done_i(cnt_done), .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc),
    .cnt_limit_o(cnt_limit), .capture_o(capture), .run_o(run)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      strap_q <= '0;
    else if (capture) strap_q <= strap_i;
  end

  assign strap_rb_o = strap_q;
  assign out_en_o   = run;

  // R8: readback moves only on the capture cycle
  a_r8_strap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture |=> $stable(strap_rb_o));
  // R5: enable rises only at the end of the lock wait
  a_r5_en_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_en_o) |-> $past(cnt_done) && !$past(capture));
endmodule

// File: tb/pgs_seq_top_tb_top.sv
module pgs_seq_top_tb_top;
  localparam int SW = 3;
  localparam int S  = 20;
  localparam int L  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg_n = 1'b1;
  logic [SW-1:0] strap = '0;
  logic [SW-1:0] rb;
  logic en;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pgs_seq_top #(.STRAP_W(SW), .SETTLE_CYC(S), .LOCK_CYC(L)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwrgood_ni(pg_n), .strap_i(strap),
    .strap_rb_o(rb), .out_en_o(en)
  );

  // vector: strap pattern, length of an aborted power-good pulse (0 = none)
  localparam logic [SW-1:0] V_STRAP [4] = '{3'b101, 3'b010, 3'b111, 3'b001};
  localparam int            V_GLITCH [4] = '{0, 5, 0, 12};

  task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pg_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input logic [SW-1:0] pat, input int glitch);
    do_reset();
    strap = ~pat;
    if (glitch > 0) begin
      pg_n = 1'b0;
      repeat (glitch) @(negedge clk);
      pg_n = 1'b1;
      repeat (S + L + 10) @(negedge clk);
      chk("R6 abort keeps enable low", {2'b0, en}, 3'b0);
      chk("R6 abort captures nothing", rb, '0);
    end
    @(negedge clk);
    pg_n = 1'b0;
    repeat (S + 3) @(posedge clk);
    @(negedge clk) strap = pat;
    @(posedge clk);
    @(negedge clk) strap = pat ^ 3'b011;
    chk("R3 strap taken on edge S+4", rb, pat);
    repeat (L - 1) @(posedge clk);
    @(negedge clk);
    chk("R5 enable low before last edge", {2'b0, en}, 3'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 enable high at edge S+L+4", {2'b0, en}, 3'b1);
    chk("R8 readback ignores later strap", rb, pat);
  endtask

  initial begin
    @(negedge clk);
    chk("R1 enable low in reset", {2'b0, en}, 3'b0);
    chk("R1 readback zero in reset", rb, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 enable low after reset", {2'b0, en}, 3'b0);

    for (int i = 0; i < 4; i++) run_vec(V_STRAP[i], V_GLITCH[i]);

    // R7: power-good toggles in running state are ignored
    for (int k = 0; k < 6; k++) begin
      pg_n = ~pg_n;
      strap = strap + 3'd1;
      repeat (3) @(negedge clk);
    end
    repeat (S + L + 10) @(negedge clk);
    chk("R7 enable stays high", {2'b0, en}, 3'b1);
    chk("R8 readback held after toggles", rb, V_STRAP[3]);

    // R9: reset during running clears and restarts
    rst_n = 1'b0;
    #1;
    chk("R9 enable drops on reset", {2'b0, en}, 3'b0);
    chk("R9 readback cleared", rb, '0);
    @(negedge clk);
    pg_n = 1'b1;
    rst_n = 1'b1;

    // R2: held high, nothing progresses
    repeat (3 * (S + L)) @(negedge clk);
    chk("R2 idle while power-good high", {2'b0, en}, 3'b0);
    chk("R2 no capture while idle", rb, '0);

    // R9: fresh sequence after reset runs normally
    run_vec(3'b110, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule